// File: doc/BRIEF.md
# Two-Stage SPI Serial Clock Generator

This block derives the serial clock of an SPI master from the main clock in two cascaded stages. The first stage is a power-of-two prescaler that emits one tick every `2 << div_sel` main-clock cycles. The second stage counts `brg_sel + 1` of those ticks per half period of the serial clock. A full serial-clock period is therefore `(2 << div_sel) * 2 * (brg_sel + 1)` main-clock cycles. The divider values cover 20 to 2048 main-clock cycles per serial-clock period.

The shift engine sees the serial clock level and two one-cycle strobes. One strobe marks the leading edge, where the clock leaves its idle level. The other marks the trailing edge, where the clock returns to idle. The idle level follows the polarity input. The divider fields and the polarity are captured only while the block is disabled. The block keeps these captured values for as long as it stays enabled. All pins are plain control and status levels, so there is no valid/ready flow and no back-pressure.

Top module: `spi_sclk_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `sclk` is low and both strobes are low.
- R2: When `en` is sampled low at a clock edge, `sclk` takes the value `cpol` had at that edge, both strobes are low, and both divider counters restart from zero. When the block is enabled again, the first transition comes a full half period after the enabling edge, whatever point the count had reached.
- R3: Each half period of `sclk` lasts `(2 << div_sel) * (brg_sel + 1)` main-clock cycles. The first transition comes at the edge exactly one half period after the first edge at which `en` is sampled high.
- R4: A `brg_sel` value below 4 gives the same timing as `brg_sel` = 4.
- R5: Changes to `div_sel`, `brg_sel` or `cpol` while `en` is high have no effect on the timing or on the idle level until the block has been disabled for at least one edge.
- R6: `lead_stb` is high for exactly one cycle, and that cycle starts at the edge where `sclk` moves away from the captured idle level. `trail_stb` behaves the same way at the edge where `sclk` returns to the idle level.
- R7: `lead_stb` and `trail_stb` are never high together. While enabled, the strobes alternate, starting with `lead_stb`.
- R8: The shortest period, `div_sel`=0 with `brg_sel`=4, is 20 main-clock cycles. The longest, `div_sel`=3 with `brg_sel`=63, is 2048 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Runs the generator when high; holds it idle and opens configuration capture when low |
| div_sel | input | DIV_W | Prescaler exponent; the prescaler divides by 2 << div_sel |
| brg_sel | input | BRG_W | Half-period tick count minus one; values below 4 act as 4 |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock level |
| lead_stb | output | 1 | One-cycle strobe when the serial clock leaves its idle level |
| trail_stb | output | 1 | One-cycle strobe when the serial clock returns to its idle level |

## Verification
The bench builds the block with its default parameters. These are a 2-bit prescaler exponent, a 6-bit half-period field and a floor of 4, so the full range from 20 to 2048 cycles per period can be reached. The bench measures exact edge positions at both ends of that range, at an intermediate setting and with a high idle level. The 4-bit prescaler counter and 6-bit tick counter are short, so the slowest setting still completes several edges in a few thousand cycles. Clamped field values, mid-run disable and restart, and field changes made while running are each timed against the formula.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;
  // Default field widths and the floor on the half-period field
  localparam int unsigned DEF_DIV_W   = 2;
  localparam int unsigned DEF_BRG_W   = 6;
  localparam int unsigned DEF_BRG_MIN = 4;

  // Kind of transition produced by the output stage in a given cycle
  typedef enum logic [1:0] {
    EDGE_NONE  = 2'd0,
    EDGE_LEAD  = 2'd1,
    EDGE_TRAIL = 2'd2
  } edge_kind_e;
endpackage

// File: rtl/sclk_cfg_hold.sv
module sclk_cfg_hold #(
  parameter int unsigned DIV_W   = 2,
  parameter int unsigned BRG_W   = 6,
  parameter int unsigned BRG_MIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_in,
  input  logic [BRG_W-1:0] brg_in,
  input  logic             cpol_in,
  output logic [DIV_W-1:0] div_q,
  output logic [BRG_W-1:0] brg_q,
  output logic             cpol_q
);
  localparam logic [BRG_W-1:0] BRG_FLOOR = BRG_W'(BRG_MIN);

  logic [BRG_W-1:0] brg_eff;

  // Raise out-of-range half-period values to the floor
  generate
    if (BRG_MIN > 0) begin : g_clamp
      always_comb brg_eff = (brg_in < BRG_FLOOR) ? BRG_FLOOR : brg_in;
    end else begin : g_pass
      always_comb brg_eff = brg_in;
    end
  endgenerate

  // Capture only while disabled
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      brg_q  <= BRG_FLOOR;
      cpol_q <= 1'b0;
    end else if (!en) begin
      div_q  <= div_in;
      brg_q  <= brg_eff;
      cpol_q <= cpol_in;
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> ($stable(div_q) && $stable(brg_q) && $stable(cpol_q))); // R5

  AST_BRG_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en) |-> (brg_q >= BRG_FLOOR)); // R4
endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler #(
  parameter int unsigned DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_q,
  output logic             tick
);
  // Largest ratio is 2 << (2**DIV_W - 1) = 2**(2**DIV_W)
  localparam int unsigned PRE_W = 2 ** DIV_W;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_last;

  always_comb pre_last = PRE_W'((32'd2 << div_q) - 32'd1);
  always_comb tick = en && (pre_cnt == pre_last);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      pre_cnt <= '0;
    end else if (pre_cnt == pre_last) begin
      pre_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (pre_cnt <= pre_last)); // R3

  AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pre_cnt == '0)); // R2
endmodule

// File: rtl/sclk_halfdiv.sv
module sclk_halfdiv #(
  parameter int unsigned BRG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [BRG_W-1:0] brg_q,
  output logic             wrap
);
  logic [BRG_W-1:0] half_cnt;

  always_comb wrap = tick && (half_cnt == brg_q);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      half_cnt <= '0;
    end else if (tick) begin
      if (half_cnt == brg_q) half_cnt <= '0;
      else                   half_cnt <= half_cnt + 1'b1;
    end
  end

  AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (half_cnt <= brg_q)); // R3

  AST_HALF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(half_cnt) || (half_cnt == '0)); // R2
endmodule

// File: rtl/sclk_edge_out.sv
module sclk_edge_out
  import sclk_gen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic wrap,
  input  logic cpol_in,
  input  logic cpol_q,
  output logic sclk,
  output logic lead_stb,
  output logic trail_stb
);
  edge_kind_e next_kind;

  // A wrap at the idle level leaves idle, otherwise it returns to idle
  always_comb begin
    next_kind = EDGE_NONE;
    if (en && wrap) next_kind = (sclk == cpol_q) ? EDGE_LEAD : EDGE_TRAIL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk      <= 1'b0;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else if (!en) begin
      sclk      <= cpol_in;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else begin
      if (next_kind != EDGE_NONE) sclk <= ~sclk;
      lead_stb  <= (next_kind == EDGE_LEAD);
      trail_stb <= (next_kind == EDGE_TRAIL);
    end
  end

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sclk == $past(cpol_in)) && !lead_stb && !trail_stb); // R2

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb && trail_stb)); // R7

  AST_LEAD_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |-> (!$stable(sclk) && (sclk != cpol_q))); // R6

  AST_TRAIL_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |-> (!$stable(sclk) && (sclk == cpol_q))); // R6

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_stb || trail_stb) |=> !(lead_stb || trail_stb)); // R6
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import sclk_gen_pkg::*;
#(
  parameter int unsigned DIV_W   = DEF_DIV_W,
  parameter int unsigned BRG_W   = DEF_BRG_W,
  parameter int unsigned BRG_MIN = DEF_BRG_MIN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [BRG_W-1:0] brg_sel,
  input  logic             cpol,
  output logic             sclk,
  output logic             lead_stb,
  output logic             trail_stb
);
  logic [DIV_W-1:0] div_q;
  logic [BRG_W-1:0] brg_q;
  logic             cpol_q;
  logic             tick;
  logic             wrap;

  sclk_cfg_hold #(
    .DIV_W  (DIV_W),
    .BRG_W  (BRG_W),
    .BRG_MIN(BRG_MIN)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .div_in (div_sel),
    .brg_in (brg_sel),
    .cpol_in(cpol),
    .div_q  (div_q),
    .brg_q  (brg_q),
    .cpol_q (cpol_q)
  );

  sclk_prescaler #(
    .DIV_W(DIV_W)
  ) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .div_q(div_q),
    .tick (tick)
  );

  sclk_halfdiv #(
    .BRG_W(BRG_W)
  ) u_half (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .tick (tick),
    .brg_q(brg_q),
    .wrap (wrap)
  );

  sclk_edge_out u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .wrap     (wrap),
    .cpol_in  (cpol),
    .cpol_q   (cpol_q),
    .sclk     (sclk),
    .lead_stb (lead_stb),
    .trail_stb(trail_stb)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!sclk && !lead_stb && !trail_stb)); // R1

  AST_WRAP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> tick); // R3
endmodule

// File: tb/sim_spi_sclk_gen.sv
module sim_spi_sclk_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] div_sel = '0;
  logic [5:0] brg_sel = 6'd4;
  logic       cpol = 1'b0;
  logic       sclk, lead_stb, trail_stb;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_sclk_gen u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .div_sel(div_sel),
    .brg_sel(brg_sel), .cpol(cpol), .sclk(sclk),
    .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Counts negedges until a strobe is seen
  task automatic wait_edge(output int cnt, output bit was_lead);
    cnt = 0;
    was_lead = 1'b0;
    for (int i = 1; i <= 5000; i++) begin
      @(negedge clk);
      if (lead_stb || trail_stb) begin
        cnt = i;
        was_lead = lead_stb;
        return;
      end
    end
  endtask

  task automatic configure(input logic [1:0] d, input logic [5:0] b, input logic p);
    @(negedge clk);
    en = 1'b0; div_sel = d; brg_sel = b; cpol = p;
    repeat (3) @(negedge clk);
    check(sclk == p && !lead_stb && !trail_stb, "R2 idle level while disabled", sclk, p);
  endtask

  // Enable and time three transitions
  task automatic run_timing(input logic [1:0] d, input logic [5:0] b, input logic p,
                            input int half, input string tag);
    int cnt;
    bit ld;
    configure(d, b, p);
    en = 1'b1;
    wait_edge(cnt, ld);
    check(cnt == half, {tag, " first edge position"}, cnt, half);
    check(ld && sclk != p, {tag, " R6 first edge is leading"}, ld, 1);
    wait_edge(cnt, ld);
    check(cnt == half, {tag, " second edge spacing"}, cnt, half);
    check(!ld && sclk == p, {tag, " R7 second edge is trailing"}, ld, 0);
    wait_edge(cnt, ld);
    check(cnt == half && ld, {tag, " third edge leading"}, cnt, half);
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check(!sclk && !lead_stb && !trail_stb, "R1 outputs during reset", sclk, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!sclk && !lead_stb && !trail_stb, "R1 outputs after reset", sclk, 0);
  endtask

  task automatic test_cpol_idle();
    @(negedge clk);
    cpol = 1'b1;
    @(negedge clk);
    check(sclk == 1'b1, "R2 idle follows cpol high", sclk, 1);
    cpol = 1'b0;
    @(negedge clk);
    check(sclk == 1'b0, "R2 idle follows cpol low", sclk, 0);
  endtask

  task automatic test_disable_midrun();
    int cnt;
    bit ld;
    configure(2'd1, 6'd5, 1'b0);
    en = 1'b1;
    wait_edge(cnt, ld);
    check(cnt == 24 && sclk, "R3 first edge before disable", cnt, 24);
    repeat (7) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(sclk == 1'b0, "R2 return to idle on disable", sclk, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!lead_stb && !trail_stb, "R2 no strobe while disabled", lead_stb, 0);
    end
    en = 1'b1;
    wait_edge(cnt, ld);
    check(cnt == 24 && ld, "R2 counters restart after re-enable", cnt, 24);
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic test_frozen_cfg();
    int cnt;
    bit ld;
    configure(2'd0, 6'd4, 1'b0);
    en = 1'b1;
    @(negedge clk);
    div_sel = 2'd3; brg_sel = 6'd20; cpol = 1'b1;
    wait_edge(cnt, ld);
    check(cnt == 9, "R5 timing unchanged while enabled", cnt + 1, 10);
    check(ld && sclk == 1'b1, "R5 idle level unchanged while enabled", sclk, 1);
    wait_edge(cnt, ld);
    check(cnt == 10 && !ld && sclk == 1'b0, "R5 trailing edge to old idle", cnt, 10);
    @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    check(sclk == 1'b1, "R5 new idle after disable", sclk, 1);
    en = 1'b1;
    wait_edge(cnt, ld);
    check(cnt == 336, "R5 new fields used after re-enable", cnt, 336);
    @(negedge clk);
    en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    test_reset();
    test_cpol_idle();
    run_timing(2'd0, 6'd4, 1'b0, 10, "R8 fastest");
    run_timing(2'd1, 6'd5, 1'b0, 24, "R3 div1 brg5");
    run_timing(2'd2, 6'd9, 1'b1, 80, "R3 high idle");
    run_timing(2'd0, 6'd2, 1'b0, 10, "R4 brg 2 clamped");
    run_timing(2'd0, 6'd0, 1'b0, 10, "R4 brg 0 clamped");
    run_timing(2'd3, 6'd63, 1'b0, 1024, "R8 slowest");
    test_disable_midrun();
    test_frozen_cfg();
    report();
  end
endmodule